// File: doc/BRIEF.md
# Angle Readout Latch with Freeze and Byte Enables

This block holds a tracking position count and presents it to a host processor. Each accepted step request from the tracking loop starts a busy pulse of fixed length, and the count moves by one when that pulse ends. A short enforced quiet interval follows each pulse. The host sees the count through a latch that is normally transparent.

Driving the active-low inhibit input freezes the latch so the host can read a stable word while tracking carries on underneath. If inhibit arrives during a busy pulse, the freeze is deferred until the pulse is over, so the host never has to poll busy. The frozen word is read through an 8-bit bus, one byte per active-low enable. With both enables active, the full word is also driven on a parallel word port.

Top module: `angle_readout_latch`

## Requirements
- R1: After reset the count is 0, busy is low, the latch is transparent, and bus_oe, bus_d, word_oe and word_d are all 0.
- R2: A step request taken in an idle cycle raises busy at that clock edge. Busy stays high for exactly BUSY_CLKS cycles. At the edge where busy falls, the count changes by +1 if step_dir was 1 or by -1 if step_dir was 0, wrapping modulo 2^WORD_W.
- R3: Between two busy pulses, busy stays low for at least GAP_CLKS cycles. With step_req held high it stays low for exactly GAP_CLKS+1 cycles. A step request made while busy is high, or during the quiet interval, has no effect on the count.
- R4: When inh_n is low at a clock edge where busy is low, the presented word freezes at the value it showed just before that edge. It stays frozen while the count keeps changing.
- R5: When inh_n goes low during a busy pulse, the latch keeps following the count until the first clock edge at which busy is already low. The frozen word therefore includes that pulse's update.
- R6: When inh_n returns high, the latch becomes transparent again at the first clock edge at which busy is low. While frozen, a release made during a busy pulse still shows the old word in the first cycle after busy falls.
- R7: With en_hi_n low, bus_d carries presented word bits [WORD_W-1:WORD_W/2] and bus_oe is 1. With only en_lo_n low, bus_d carries bits [WORD_W/2-1:0] and bus_oe is 1.
- R8: With both enables high, bus_oe is 0 and bus_d is 0, which is the high-impedance state.
- R9: With both enables low, bus_d carries the upper byte, word_oe is 1 and word_d is the full presented word. In every other case word_oe and word_d are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_req | input | 1 | Step request from the tracking loop |
| step_dir | input | 1 | Step direction, 1 = up, 0 = down |
| inh_n | input | 1 | Active-low freeze request |
| en_hi_n | input | 1 | Active-low enable for the upper byte |
| en_lo_n | input | 1 | Active-low enable for the lower byte |
| busy | output | 1 | High while a count update is in progress |
| bus_d | output | WORD_W/2 | Byte bus data |
| bus_oe | output | 1 | Byte bus drive enable |
| word_d | output | WORD_W | Full word data, valid when both enables are low |
| word_oe | output | 1 | Full word drive enable |

## Verification
The bench aims at the deferral window. Inhibit is asserted in the middle of a busy pulse, and the frozen word must include that pulse's update. A design that froze at once would hold the stale count. It also releases inhibit during a pulse while frozen, to catch a latch that reopens one cycle early. Step requests are fired inside busy and inside the quiet interval, so a design that queued or took them would show an extra count. Counting down from zero must give all ones. Driving both enables together must put the upper byte on the bus, not the lower one and not a merged value.

// File: rtl/angle_readout_latch.sv
module angle_readout_latch #(
  parameter int WORD_W    = 16,
  parameter int BUSY_CLKS = 4,
  parameter int GAP_CLKS  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step_req,
  input  logic                  step_dir,
  input  logic                  inh_n,
  input  logic                  en_hi_n,
  input  logic                  en_lo_n,
  output logic                  busy,
  output logic [WORD_W/2-1:0]   bus_d,
  output logic                  bus_oe,
  output logic [WORD_W-1:0]     word_d,
  output logic                  word_oe
);
  localparam int BYTE_W  = WORD_W / 2;
  localparam int TMR_MAX = (BUSY_CLKS > GAP_CLKS) ? BUSY_CLKS : GAP_CLKS;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] BUSY_LOAD = TMR_W'(BUSY_CLKS - 1);
  localparam logic [TMR_W-1:0] GAP_LOAD  = TMR_W'(GAP_CLKS - 1);
  localparam logic [TMR_W-1:0] BUSY_LEN  = TMR_W'(BUSY_CLKS);
  localparam logic [TMR_W-1:0] GAP_LEN   = TMR_W'(GAP_CLKS);

  logic [WORD_W-1:0] cnt_q, lat_q, rd_word;
  logic [TMR_W-1:0]  tmr_q;
  logic              busy_q, gap_q, dir_q, frz_q, accept;

  assign accept = step_req && !busy_q && !gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      gap_q  <= 1'b0;
      dir_q  <= 1'b0;
      tmr_q  <= '0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      dir_q  <= step_dir;
      tmr_q  <= BUSY_LOAD;
    end else if (busy_q) begin
      if (tmr_q == '0) begin
        busy_q <= 1'b0;
        gap_q  <= 1'b1;
        tmr_q  <= GAP_LOAD;
        cnt_q  <= dir_q ? cnt_q + 1'b1 : cnt_q - 1'b1;
      end else begin
        tmr_q <= tmr_q - 1'b1;
      end
    end else if (gap_q) begin
      if (tmr_q == '0) gap_q <= 1'b0;
      else             tmr_q <= tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frz_q <= 1'b0;
      lat_q <= '0;
    end else begin
      if (!frz_q)  lat_q <= cnt_q;
      if (!busy_q) frz_q <= !inh_n;
    end
  end

  assign rd_word = frz_q ? lat_q : cnt_q;
  assign busy    = busy_q;
  assign bus_oe  = !en_hi_n || !en_lo_n;
  assign bus_d   = !en_hi_n ? rd_word[WORD_W-1:BYTE_W]
                 : (!en_lo_n ? rd_word[BYTE_W-1:0] : '0);
  assign word_oe = !en_hi_n && !en_lo_n;
  assign word_d  = word_oe ? rd_word : '0;

  // checker state: run lengths of busy high and busy low
  logic [TMR_W-1:0] busy_len_q, low_len_q;
  logic             seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_len_q <= '0;
      low_len_q  <= '0;
      seen_q     <= 1'b0;
    end else begin
      busy_len_q <= busy_q ? busy_len_q + 1'b1 : '0;
      if (busy_q)                 low_len_q <= '0;
      else if (low_len_q != GAP_LEN) low_len_q <= low_len_q + 1'b1;
      if (busy_q) seen_q <= 1'b1;
    end
  end

  assert_busy_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> busy_len_q == BUSY_LEN);

  assert_count_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> cnt_q != $past(cnt_q));

  assert_quiet_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_q) && seen_q) |-> low_len_q >= GAP_LEN);

  assert_frozen_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && $past(frz_q)) |-> $stable(rd_word));

  assert_freeze_deferred_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_q) |-> $stable(frz_q));

  assert_bus_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_hi_n && en_lo_n) |-> (!bus_oe && !word_oe));
endmodule

// File: tb/angle_readout_latch_tb.sv
module angle_readout_latch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 16;
  localparam int BUSY_CLKS = 4;
  localparam int GAP_CLKS = 2;

  logic clk = 1'b0, rst_n = 1'b0, step_req = 1'b0, step_dir = 1'b0, inh_n = 1'b1;
  logic en_hi_n = 1'b1, en_lo_n = 1'b1;
  logic busy, bus_oe, word_oe;
  logic [7:0] bus_d;
  logic [15:0] word_d;
  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_w;

  always #(CLK_PERIOD/2) clk = ~clk;

  angle_readout_latch #(.WORD_W(WORD_W), .BUSY_CLKS(BUSY_CLKS), .GAP_CLKS(GAP_CLKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .step_req(step_req), .step_dir(step_dir), .inh_n(inh_n),
    .en_hi_n(en_hi_n), .en_lo_n(en_lo_n), .busy(busy), .bus_d(bus_d), .bus_oe(bus_oe),
    .word_d(word_d), .word_oe(word_oe));

  // {en_hi_n, en_lo_n, exp_oe, exp_word_oe, exp_sel(0 none,1 hi,2 lo)}
  localparam logic [5:0] VEC [6] = '{
    {2'b11, 1'b0, 1'b0, 2'd0}, {2'b01, 1'b1, 1'b0, 2'd1}, {2'b10, 1'b1, 1'b0, 2'd2},
    {2'b00, 1'b1, 1'b1, 2'd1}, {2'b10, 1'b1, 1'b0, 2'd2}, {2'b11, 1'b0, 1'b0, 2'd0}};

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic peek(output logic [15:0] w);
    en_hi_n = 1'b0; en_lo_n = 1'b0; #1;
    w = word_d;
    en_hi_n = 1'b1; en_lo_n = 1'b1; #1;
  endtask

  task automatic go_idle();
    while (busy) cyc();
    repeat (GAP_CLKS + 1) cyc();
  endtask

  task automatic do_step(input logic dir, output int width);
    go_idle();
    step_req = 1'b1; step_dir = dir;
    cyc();
    step_req = 1'b0;
    width = 0;
    while (busy && width < 50) begin width++; cyc(); end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] w;
    int width, lows;
    logic extra;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 bus_oe", bus_oe, 0);
    chk("R1 bus_d", bus_d, 0);
    chk("R1 word_oe", word_oe, 0);
    peek(w); chk("R1 count", w, 16'h0000);

    // R2 down-wrap, width, up steps
    do_step(1'b0, width);
    chk("R2 busy width", width, BUSY_CLKS);
    peek(w); chk("R2 wrap down", w, 16'hFFFF);
    do_step(1'b1, width);
    peek(w); chk("R2 wrap up", w, 16'h0000);
    do_step(1'b1, width);
    chk("R2 busy width up", width, BUSY_CLKS);
    peek(w); chk("R2 count up", w, 16'h0001);
    exp_w = 16'h0001;

    // R7 R8 R9 enable vector table
    go_idle();
    foreach (VEC[i]) begin
      en_hi_n = VEC[i][5]; en_lo_n = VEC[i][4]; #1;
      chk("R7 R8 bus_oe", bus_oe, VEC[i][3]);
      chk("R9 word_oe", word_oe, VEC[i][2]);
      chk("R9 word_d", word_d, VEC[i][2] ? exp_w : 16'h0);
      chk("R7 R8 R9 bus_d", bus_d,
          VEC[i][1:0] == 2'd1 ? exp_w[15:8] : (VEC[i][1:0] == 2'd2 ? exp_w[7:0] : 8'h00));
      cyc();
    end
    en_hi_n = 1'b1; en_lo_n = 1'b1;

    // R3 requests during busy and quiet interval are ignored
    go_idle();
    step_req = 1'b1; step_dir = 1'b1; cyc(); step_req = 1'b0;
    cyc(); step_req = 1'b1; cyc(); step_req = 1'b0;
    while (busy) cyc();
    step_req = 1'b1; cyc(); step_req = 1'b0;
    extra = 1'b0;
    repeat (10) begin cyc(); if (busy) extra = 1'b1; end
    chk("R3 no extra pulse", extra, 0);
    exp_w = exp_w + 1;
    peek(w); chk("R3 ignored requests", w, exp_w);

    // R3 exact spacing with request held
    go_idle();
    step_req = 1'b1; step_dir = 1'b1;
    cyc();
    while (busy) cyc();
    lows = 0;
    while (!busy && lows < 50) begin lows++; cyc(); end
    step_req = 1'b0;
    chk("R3 gap length", lows, GAP_CLKS + 1);
    while (busy) cyc();
    exp_w = exp_w + 2;
    peek(w); chk("R3 two steps", w, exp_w);

    // R4 freeze in idle, count keeps moving
    go_idle();
    inh_n = 1'b0; cyc();
    peek(w); chk("R4 frozen", w, exp_w);
    do_step(1'b1, width);
    peek(w); chk("R4 held over step", w, exp_w);
    en_lo_n = 1'b0; #1; chk("R4 low byte held", bus_d, exp_w[7:0]); en_lo_n = 1'b1;

    // R6 release in idle
    inh_n = 1'b1; cyc();
    exp_w = exp_w + 1;
    peek(w); chk("R6 reopen idle", w, exp_w);

    // R6 release during busy while frozen
    go_idle();
    inh_n = 1'b0; cyc();
    step_req = 1'b1; step_dir = 1'b1; cyc(); step_req = 1'b0;
    inh_n = 1'b1;
    while (busy) cyc();
    peek(w); chk("R6 still frozen after busy", w, exp_w);
    cyc();
    exp_w = exp_w + 1;
    peek(w); chk("R6 reopen after busy", w, exp_w);

    // R5 freeze requested during busy
    go_idle();
    step_req = 1'b1; step_dir = 1'b0; cyc(); step_req = 1'b0;
    cyc();
    inh_n = 1'b0;
    while (busy) cyc();
    exp_w = exp_w - 1;
    peek(w); chk("R5 update visible", w, exp_w);
    cyc();
    do_step(1'b0, width);
    peek(w); chk("R5 froze with update", w, exp_w);
    inh_n = 1'b1; cyc();
    exp_w = exp_w - 1;
    peek(w); chk("R5 R6 reopen", w, exp_w);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule